// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reconfigures one PLL through a simple register read/write port, with no processor involved. A `start` pulse supplies a frequency index (0 to 4) and a silicon-revision select. The block takes multiplier, divider, frequency-range and post-divider values from an internal table. It then takes the PLL out of lock, programs the new values and locks it again, polling a status bit between these phases.

Every field update is a read of the register followed by a write. The write changes only the bits of the target field. The post-divider field is written twice, first with its target value plus one and then with the target value, because the register does not act on a write that repeats its default value. Each status poll has a limit on how many times it reads the status. When a poll reaches that limit, or the index is out of range, the block gives an error pulse instead of a completion pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: Only one bus transaction runs at a time. `bus_req` stays high until the cycle in which `bus_ack` is sampled high, and `bus_addr`, `bus_we` and `bus_wdata` do not change while the request waits.
- R2: After a valid start, the first write puts the stop code 3'b001 into control register (address 0) bits [2:0]. The block then reads status register (address 3) bit 0 until it reads 0.
- R3: Next, post-divider register (address 2) bits [4:0] receive two writes in a row: first the table value plus one, then the table value.
- R4: After the post-divider writes, M goes into divide register (address 1) bits [18:8], then N into bits [6:0], then the frequency-range value into control bits [7:4]. These are the only writes between the post-divider writes and the lock write.
- R5: The lock code 3'b111 is written into control bits [2:0] only after every divider field has been written. The block then polls status bit 0 until it reads 1, and then raises `done` for exactly one cycle.
- R6: Each field write is a read of the register followed by a write. The bits of the written word outside the field equal the value just read. `bus_wmask` equals the field mask on writes and is zero on reads.
- R7: The table row is chosen by index and revision, as {M, N, range, post-divider}. Revision 0: 0:{19F,0E,3,1} 1:{1B2,10,3,1} 2:{19F,17,3,1} 3:{1B2,21,3,1} 4:{19F,2F,3,1}. Revision 1: 0:{0A6,05,7,2} 1:{14C,0C,3,2} 2:{19F,17,3,2} 3:{0A6,0C,7,2} 4:{19F,2F,3,2}. All values are hexadecimal.
- R8: Each poll allows POLL_LIMIT (default 8) status reads, and a match on the last allowed read still succeeds. If all of them mismatch, `err` pulses for one cycle, the block returns to idle, and it issues no further write.
- R9: A start with an index above 4 pulses `err` in the next cycle and issues no bus transaction at all.
- R10: A start that arrives while a sequence is running is ignored. The sequence in progress finishes with its own parameters and a single `done`.
- R11: `done` and `err` are never high in the same cycle, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reprogramming sequence (ignored unless idle) |
| freq_idx | input | 3 | Input-frequency row index, 0 to 4 valid |
| rev_sel | input | 1 | Parameter set select |
| done | output | 1 | One-cycle pulse when lock status is seen |
| err | output | 1 | One-cycle pulse on bad index or poll timeout |
| bus_req | output | 1 | Transaction request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Merged write word |
| bus_wmask | output | 32 | Mask of the field being changed |
| bus_ack | input | 1 | Transaction acknowledge, one cycle |
| bus_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
Two checks can fall in the same cycle: a status read that finally matches the expected lock state, and the poll limit running out. The bench's register model holds back the status change for a chosen number of reads. Setting that number to one less than the limit lands the match on the last allowed read, and the run must end in `done`. Setting it equal to the limit must end in `err` with no later write. This is exercised separately on the unlock poll and on the lock poll.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   localparam int MODE_W = 3;
   localparam int M_W    = 11;
   localparam int N_W    = 7;
   localparam int FS_W   = 4;
   localparam int M2_W   = 5;

   localparam logic [MODE_W-1:0] MODE_STOP = 3'b001;
   localparam logic [MODE_W-1:0] MODE_LOCK = 3'b111;

   localparam int IDX_W     = 3;
   localparam int IDX_MAX   = 4;
   localparam int STEP_W    = 4;
   localparam int LAST_STEP = 8;

   typedef struct packed {
      logic [M_W-1:0]  m;
      logic [N_W-1:0]  n;
      logic [FS_W-1:0] fsel;
      logic [M2_W-1:0] m2;
   } pll_row_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DISP,
      S_RD,
      S_WR,
      S_POLL
   } seq_state_t;

   function automatic logic [31:0] fmask(input int sh, input int w);
      return ((32'd1 << w) - 32'd1) << sh;
   endfunction

   function automatic logic [31:0] fput(input int sh, input int w, input logic [31:0] v);
      return (v << sh) & fmask(sh, w);
   endfunction

endpackage

// File: rtl/pll_param_rom.sv
module pll_param_rom
   import pll_seq_pkg::*;
#(
   parameter int NUM_REV = 2
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             rev,
   output pll_row_t         row
);

   if (NUM_REV != 2) begin : g_bad_rev
      $error("pll_param_rom: table holds exactly two parameter sets");
   end

   always_comb begin
      row = '0;
      unique case ({rev, idx})
         {1'b0, 3'd0}: row = '{m: 11'h19F, n: 7'h0E, fsel: 4'h3, m2: 5'd1};
         {1'b0, 3'd1}: row = '{m: 11'h1B2, n: 7'h10, fsel: 4'h3, m2: 5'd1};
         {1'b0, 3'd2}: row = '{m: 11'h19F, n: 7'h17, fsel: 4'h3, m2: 5'd1};
         {1'b0, 3'd3}: row = '{m: 11'h1B2, n: 7'h21, fsel: 4'h3, m2: 5'd1};
         {1'b0, 3'd4}: row = '{m: 11'h19F, n: 7'h2F, fsel: 4'h3, m2: 5'd1};
         {1'b1, 3'd0}: row = '{m: 11'h0A6, n: 7'h05, fsel: 4'h7, m2: 5'd2};
         {1'b1, 3'd1}: row = '{m: 11'h14C, n: 7'h0C, fsel: 4'h3, m2: 5'd2};
         {1'b1, 3'd2}: row = '{m: 11'h19F, n: 7'h17, fsel: 4'h3, m2: 5'd2};
         {1'b1, 3'd3}: row = '{m: 11'h0A6, n: 7'h0C, fsel: 4'h7, m2: 5'd2};
         {1'b1, 3'd4}: row = '{m: 11'h19F, n: 7'h2F, fsel: 4'h3, m2: 5'd2};
         default:      row = '0;
      endcase
   end

endmodule

// File: rtl/pll_step_decode.sv
module pll_step_decode
   import pll_seq_pkg::*;
#(
   parameter int AW      = 4,
   parameter int CTRL_A  = 0,
   parameter int DIV_A   = 1,
   parameter int POST_A  = 2,
   parameter int STAT_A  = 3,
   parameter int MODE_SH = 0,
   parameter int FS_SH   = 4,
   parameter int M_SH    = 8,
   parameter int N_SH    = 0,
   parameter int M2_SH   = 0
) (
   input  logic [STEP_W-1:0] step,
   input  pll_row_t          row,
   output logic              is_poll,
   output logic              target,
   output logic              last,
   output logic [AW-1:0]     addr,
   output logic [31:0]       mask,
   output logic [31:0]       value
);

   if (MODE_SH + MODE_W > 32 || FS_SH + FS_W > 32 || M_SH + M_W > 32 ||
       N_SH + N_W > 32 || M2_SH + M2_W > 32) begin : g_bad_fit
      $error("pll_step_decode: a field runs past bit 31");
   end
   if (!(MODE_SH + MODE_W <= FS_SH || FS_SH + FS_W <= MODE_SH)) begin : g_ctrl_overlap
      $error("pll_step_decode: mode and range fields overlap");
   end
   if (!(M_SH + M_W <= N_SH || N_SH + N_W <= M_SH)) begin : g_div_overlap
      $error("pll_step_decode: multiplier and divider fields overlap");
   end

   always_comb begin
      is_poll = 1'b0;
      target  = 1'b0;
      last    = 1'b0;
      addr    = AW'(CTRL_A);
      mask    = '0;
      value   = '0;
      unique case (step)
         4'd0: begin
            mask  = fmask(MODE_SH, MODE_W);
            value = fput(MODE_SH, MODE_W, 32'(MODE_STOP));
         end
         4'd1: begin
            is_poll = 1'b1;
            addr    = AW'(STAT_A);
         end
         4'd2: begin
            addr  = AW'(POST_A);
            mask  = fmask(M2_SH, M2_W);
            value = fput(M2_SH, M2_W, 32'(row.m2) + 32'd1);
         end
         4'd3: begin
            addr  = AW'(POST_A);
            mask  = fmask(M2_SH, M2_W);
            value = fput(M2_SH, M2_W, 32'(row.m2));
         end
         4'd4: begin
            addr  = AW'(DIV_A);
            mask  = fmask(M_SH, M_W);
            value = fput(M_SH, M_W, 32'(row.m));
         end
         4'd5: begin
            addr  = AW'(DIV_A);
            mask  = fmask(N_SH, N_W);
            value = fput(N_SH, N_W, 32'(row.n));
         end
         4'd6: begin
            mask  = fmask(FS_SH, FS_W);
            value = fput(FS_SH, FS_W, 32'(row.fsel));
         end
         4'd7: begin
            mask  = fmask(MODE_SH, MODE_W);
            value = fput(MODE_SH, MODE_W, 32'(MODE_LOCK));
         end
         4'd8: begin
            is_poll = 1'b1;
            target  = 1'b1;
            last    = 1'b1;
            addr    = AW'(STAT_A);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic last
);

   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pll_poll_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (bump && !last) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int AW         = 4,
   parameter int POLL_LIMIT = 8,
   parameter int CTRL_A     = 0,
   parameter int DIV_A      = 1,
   parameter int POST_A     = 2,
   parameter int STAT_A     = 3,
   parameter int STAT_BIT   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    freq_idx,
   input  logic          rev_sel,
   output logic          done,
   output logic          err,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [31:0]   bus_wdata,
   output logic [31:0]   bus_wmask,
   input  logic          bus_ack,
   input  logic [31:0]   bus_rdata
);

   if (CTRL_A == DIV_A || CTRL_A == POST_A || CTRL_A == STAT_A ||
       DIV_A == POST_A || DIV_A == STAT_A || POST_A == STAT_A) begin : g_bad_addr
      $error("pll_reprog_seq: register addresses must be distinct");
   end
   if (STAT_BIT < 0 || STAT_BIT > 31) begin : g_bad_bit
      $error("pll_reprog_seq: status bit out of range");
   end
   if ((1 << AW) <= CTRL_A || (1 << AW) <= DIV_A ||
       (1 << AW) <= POST_A || (1 << AW) <= STAT_A) begin : g_bad_aw
      $error("pll_reprog_seq: address does not fit AW");
   end

   seq_state_t        state_q;
   logic [STEP_W-1:0] step_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rev_q;
   logic [31:0]       rdval_q;
   logic              done_q, err_q;
   logic              busy;

   pll_row_t          row;
   logic              op_poll, op_target, op_last;
   logic [AW-1:0]     op_addr;
   logic [31:0]       op_mask, op_value;
   logic              tmr_last;
   logic              stat_match;

   pll_param_rom u_rom (
      .idx (idx_q),
      .rev (rev_q),
      .row (row)
   );

   pll_step_decode #(
      .AW     (AW),
      .CTRL_A (CTRL_A),
      .DIV_A  (DIV_A),
      .POST_A (POST_A),
      .STAT_A (STAT_A)
   ) u_dec (
      .step    (step_q),
      .row     (row),
      .is_poll (op_poll),
      .target  (op_target),
      .last    (op_last),
      .addr    (op_addr),
      .mask    (op_mask),
      .value   (op_value)
   );

   pll_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == S_DISP),
      .bump  (state_q == S_POLL && bus_ack && !stat_match),
      .last  (tmr_last)
   );

   assign busy       = (state_q != S_IDLE);
   assign stat_match = (bus_rdata[STAT_BIT] == op_target);

   always_comb begin
      bus_req   = (state_q == S_RD) || (state_q == S_WR) || (state_q == S_POLL);
      bus_we    = (state_q == S_WR);
      bus_addr  = op_addr;
      bus_wdata = (state_q == S_WR) ? ((rdval_q & ~op_mask) | op_value) : '0;
      bus_wmask = (state_q == S_WR) ? op_mask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         step_q  <= '0;
         idx_q   <= '0;
         rev_q   <= 1'b0;
         rdval_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start && !busy) begin
                  if (freq_idx > IDX_W'(IDX_MAX)) begin
                     err_q <= 1'b1;
                  end else begin
                     idx_q   <= freq_idx;
                     rev_q   <= rev_sel;
                     step_q  <= '0;
                     state_q <= S_DISP;
                  end
               end
            end
            S_DISP: state_q <= op_poll ? S_POLL : S_RD;
            S_RD: begin
               if (bus_ack) begin
                  rdval_q <= bus_rdata;
                  state_q <= S_WR;
               end
            end
            S_WR: begin
               if (bus_ack) begin
                  step_q  <= step_q + STEP_W'(1);
                  state_q <= S_DISP;
               end
            end
            S_POLL: begin
               if (bus_ack) begin
                  if (stat_match) begin
                     if (op_last) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                     end else begin
                        step_q  <= step_q + STEP_W'(1);
                        state_q <= S_DISP;
                     end
                  end else if (tmr_last) begin
                     err_q   <= 1'b1;
                     state_q <= S_IDLE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign err  = err_q;

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [2:0]    freq_idx,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          bus_req,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_wmask,
   input logic          bus_ack
);

   a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_read_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we |-> bus_wmask == 32'd0);

   a_r6_write_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we |-> bus_wmask != 32'd0);

   a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   a_r9_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && freq_idx > 3'd4 |=> err && !bus_req);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .freq_idx  (freq_idx),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wmask (bus_wmask),
   .bus_ack   (bus_ack)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;

   localparam int AW    = 4;
   localparam int LIMIT = 8;
   localparam logic [31:0] PRE_CTRL = 32'h5A5A_5A5A;
   localparam logic [31:0] PRE_DIV  = 32'hC3C3_C3C3;
   localparam logic [31:0] PRE_POST = 32'h9696_9696;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    freq_idx = '0;
   logic          rev_sel = 1'b0;
   logic          done, err;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata, bus_wmask;
   logic          bus_ack;
   logic [31:0]   bus_rdata;

   always #10 clk = ~clk;

   pll_reprog_seq #(.AW(AW), .POLL_LIMIT(LIMIT)) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .freq_idx (freq_idx),
      .rev_sel (rev_sel), .done (done), .err (err), .bus_req (bus_req),
      .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wmask (bus_wmask), .bus_ack (bus_ack), .bus_rdata (bus_rdata)
   );

   // Register-file model of the PLL with a delayed status response.
   logic [31:0] rf [0:3];
   logic        stat_q, tgt_q, pre_go;
   int          pend, lag_stop, lag_lock;
   int          wr_n, txn_n, done_n, err_n, rmw_bad;
   logic [AW-1:0] wl_addr [0:15];
   logic [31:0]   wl_data [0:15];

   initial begin
      pre_go = 1'b0; lag_stop = 0; lag_lock = 0;
   end

   always @(posedge clk) begin
      if (done) done_n <= done_n + 1;
      if (err)  err_n  <= err_n + 1;
      if (!rst_n) begin
         bus_ack <= 1'b0; bus_rdata <= '0; stat_q <= 1'b1; tgt_q <= 1'b1;
         pend <= 0; wr_n <= 0; txn_n <= 0; done_n <= 0; err_n <= 0; rmw_bad <= 0;
         rf[0] <= PRE_CTRL; rf[1] <= PRE_DIV; rf[2] <= PRE_POST; rf[3] <= '0;
      end else if (pre_go) begin
         rf[0] <= PRE_CTRL; rf[1] <= PRE_DIV; rf[2] <= PRE_POST;
         wr_n <= 0;
      end else if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         txn_n   <= txn_n + 1;
         if (bus_we) begin
            if ((bus_wdata & ~bus_wmask) != (rf[bus_addr[1:0]] & ~bus_wmask))
               rmw_bad <= rmw_bad + 1;
            rf[bus_addr[1:0]] <= bus_wdata;
            if (wr_n < 16) begin
               wl_addr[wr_n] <= bus_addr;
               wl_data[wr_n] <= bus_wdata;
            end
            wr_n <= wr_n + 1;
            if (bus_addr == 0) begin
               tgt_q <= (bus_wdata[2:0] == 3'b111);
               pend  <= 0;
            end
         end else if (bus_addr == 3) begin
            if (stat_q == tgt_q) begin
               bus_rdata <= {31'b0, stat_q};
            end else if (pend < (tgt_q ? lag_lock : lag_stop)) begin
               pend <= pend + 1;
               bus_rdata <= {31'b0, stat_q};
            end else begin
               stat_q <= tgt_q;
               bus_rdata <= {31'b0, tgt_q};
            end
         end else begin
            bus_rdata <= rf[bus_addr[1:0]];
         end
      end else begin
         bus_ack <= 1'b0;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Independent reference table (R7): {m, n, fsel, m2}
   function automatic logic [26:0] ref_row(input int idx, input bit rev);
      logic [26:0] r;
      case ({rev, 3'(idx)})
         {1'b0, 3'd0}: r = {11'h19F, 7'h0E, 4'h3, 5'd1};
         {1'b0, 3'd1}: r = {11'h1B2, 7'h10, 4'h3, 5'd1};
         {1'b0, 3'd2}: r = {11'h19F, 7'h17, 4'h3, 5'd1};
         {1'b0, 3'd3}: r = {11'h1B2, 7'h21, 4'h3, 5'd1};
         {1'b0, 3'd4}: r = {11'h19F, 7'h2F, 4'h3, 5'd1};
         {1'b1, 3'd0}: r = {11'h0A6, 7'h05, 4'h7, 5'd2};
         {1'b1, 3'd1}: r = {11'h14C, 7'h0C, 4'h3, 5'd2};
         {1'b1, 3'd2}: r = {11'h19F, 7'h17, 4'h3, 5'd2};
         {1'b1, 3'd3}: r = {11'h0A6, 7'h0C, 4'h7, 5'd2};
         default:      r = {11'h19F, 7'h2F, 4'h3, 5'd2};
      endcase
      return r;
   endfunction

   task automatic preload();
      @(negedge clk) pre_go = 1'b1;
      @(negedge clk) pre_go = 1'b0;
   endtask

   task automatic launch(input int idx, input bit rev, output int d0, output int e0, output int t0);
      d0 = done_n; e0 = err_n; t0 = txn_n;
      @(negedge clk);
      start = 1'b1; freq_idx = 3'(idx); rev_sel = rev;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end(input int d0, input int e0);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done_n != d0 || err_n != e0) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_full(input int idx, input bit rev, input int d0, input int e0);
      logic [26:0] r;
      logic [10:0] m; logic [6:0] n; logic [3:0] fs; logic [4:0] m2;
      r = ref_row(idx, rev);
      {m, n, fs, m2} = r;
      check(done_n - d0 == 1 && err_n == e0, "R5 single done", 32'(done_n - d0), 32'd1);
      check(wr_n == 7, "R4 write count", 32'(wr_n), 32'd7);
      check(rmw_bad == 0, "R6 bits outside field kept", 32'(rmw_bad), 32'd0);
      check(wl_addr[0] == 0 && wl_data[0][2:0] == 3'b001, "R2 stop first", wl_data[0], 32'h1);
      check(wl_addr[1] == 2 && wl_data[1][4:0] == m2 + 5'd1, "R3 post value+1", wl_data[1], 32'(m2 + 5'd1));
      check(wl_addr[2] == 2 && wl_data[2][4:0] == m2, "R3 post value", wl_data[2], 32'(m2));
      check(wl_addr[3] == 1 && wl_data[3][18:8] == m, "R4 multiplier", wl_data[3], 32'(m) << 8);
      check(wl_addr[4] == 1 && wl_data[4][6:0] == n, "R4 divider", wl_data[4], 32'(n));
      check(wl_addr[5] == 0 && wl_data[5][7:4] == fs, "R4 range", wl_data[5], 32'(fs) << 4);
      check(wl_addr[6] == 0 && wl_data[6][2:0] == 3'b111, "R5 lock last", wl_data[6], 32'h7);
      check(rf[0] == ((PRE_CTRL & ~32'hF7) | (32'(fs) << 4) | 32'h7), "R7 control final",
            rf[0], (PRE_CTRL & ~32'hF7) | (32'(fs) << 4) | 32'h7);
      check(rf[1] == ((PRE_DIV & ~32'h7_FF7F) | (32'(m) << 8) | 32'(n)), "R7 divide final",
            rf[1], (PRE_DIV & ~32'h7_FF7F) | (32'(m) << 8) | 32'(n));
      check(rf[2] == ((PRE_POST & ~32'h1F) | 32'(m2)), "R7 post final",
            rf[2], (PRE_POST & ~32'h1F) | 32'(m2));
   endtask

   task automatic t_reset();
      check(done === 1'b0 && err === 1'b0, "R11 reset outputs", {30'b0, done, err}, 32'd0);
      check(bus_req === 1'b0, "R1 reset idle bus", {31'b0, bus_req}, 32'd0);
   endtask

   task automatic t_normal(input int idx, input bit rev, input int ls, input int ll);
      int d0, e0, t0;
      lag_stop = ls; lag_lock = ll;
      preload();
      launch(idx, rev, d0, e0, t0);
      wait_end(d0, e0);
      check_full(idx, rev, d0, e0);
   endtask

   task automatic t_bad_index(input int idx);
      int d0, e0, t0;
      preload();
      launch(idx, 1'b0, d0, e0, t0);
      repeat (6) @(negedge clk);
      check(err_n - e0 == 1 && done_n == d0, "R9 error pulse", 32'(err_n - e0), 32'd1);
      check(txn_n == t0, "R9 no transaction", 32'(txn_n - t0), 32'd0);
   endtask

   task automatic t_stop_timeout();
      int d0, e0, t0;
      lag_stop = LIMIT; lag_lock = 0;
      preload();
      launch(0, 1'b0, d0, e0, t0);
      wait_end(d0, e0);
      check(err_n - e0 == 1 && done_n == d0, "R8 unlock poll timeout", 32'(err_n - e0), 32'd1);
      check(wr_n == 1 && rf[2] == PRE_POST, "R8 no write after timeout", 32'(wr_n), 32'd1);
   endtask

   task automatic t_lock_timeout();
      int d0, e0, t0;
      lag_stop = 0; lag_lock = LIMIT;
      preload();
      launch(4, 1'b1, d0, e0, t0);
      wait_end(d0, e0);
      check(err_n - e0 == 1 && done_n == d0, "R8 lock poll timeout", 32'(err_n - e0), 32'd1);
      check(wr_n == 7, "R8 writes before lock timeout", 32'(wr_n), 32'd7);
   endtask

   task automatic t_restart_ignored();
      int d0, e0, t0;
      lag_stop = 3; lag_lock = 3;
      preload();
      launch(1, 1'b0, d0, e0, t0);
      repeat (10) @(negedge clk);
      start = 1'b1; freq_idx = 3'd3; rev_sel = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; freq_idx = 3'd6;
      @(negedge clk) start = 1'b0;
      wait_end(d0, e0);
      check(err_n == e0, "R10 no error from busy start", 32'(err_n - e0), 32'd0);
      check_full(1, 1'b0, d0, e0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_normal(0, 1'b0, 2, 2);
      t_normal(3, 1'b1, 0, 5);
      for (int rv = 0; rv < 2; rv++)
         for (int ix = 0; ix < 5; ix++)
            t_normal(ix, rv[0], ix, 4 - ix);
      t_normal(2, 1'b1, LIMIT - 1, LIMIT - 1);
      t_bad_index(5);
      t_bad_index(7);
      t_stop_timeout();
      t_lock_timeout();
      t_normal(4, 1'b0, 1, 1);
      t_restart_ignored();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule